// File: doc/BRIEF.md
# Stacked-Plane Steep-Segment Coincidence Unit

This unit pairs hits from two detector planes mounted close together, so that only steep track segments from high-momentum particles are kept. The local plane gives one row of pixels as a bit vector. The partner plane does not send a bit vector. It sends the column numbers of its hits, one per clock, each with a valid strobe.

For every partner column, a barrel shifter built from binary stages moves the local row so that the partner column falls on position zero. A programmable enable window then masks the moved row. A lowest-index-first encoder turns the surviving bits into a single index, and that index is the segment's angle. A single copy of this datapath serves every column position, so the coincidence logic is not repeated once per column.

Software sets the window through a word-wide write port. The window decides which angles pass. Moving the window along the row corrects for a fixed misalignment between the two planes, and making it narrower or wider tightens or loosens the momentum cut.

Top module: `dbl_correlator`

## Requirements
- R1: While reset is high, and on the first clock after it, every bit of the enable window is 0 and `res_valid_o`, `match_o`, `angle_o` and `coord_o` are 0. With an all-zero window no hit ever matches.
- R2: A write with `wr_en_i`=1 loads `wr_data_i` into window bits [k*DATA_W +: DATA_W], where k = `wr_addr_i`. An address of NWORDS or more changes nothing. The new value applies from the next clock, so a partner hit in the same cycle as the write is judged against the old window.
- R3: For partner column c, the aligned row has bit i equal to local bit i+c when i+c < WIDTH, and 0 otherwise. Nothing wraps around.
- R4: `match_o` is 1 exactly when some i has both aligned bit i and window bit i set.
- R5: `angle_o` is the lowest i that satisfies R4. When there is no match, `angle_o` is 0.
- R6: A partner hit accepted at clock edge t (`coord_valid_i`=1) produces `res_valid_o`=1 on the cycle after edge t. On that cycle `coord_o` repeats the column, and `match_o` and `angle_o` follow from the local row and the window as they were sampled at edge t.
- R7: After a cycle with `coord_valid_i`=0, `res_valid_o`, `match_o` and `angle_o` are 0, and `coord_o` keeps its previous value.
- R8: A window write without a partner hit produces no result: `res_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Window write strobe |
| wr_addr_i | input | ADDR_W | Index of the window word to write |
| wr_data_i | input | DATA_W | Window word data |
| local_hits_i | input | WIDTH | Hit bit vector of the local plane |
| coord_valid_i | input | 1 | Partner column is valid |
| coord_i | input | COORD_W | Partner hit column |
| res_valid_o | output | 1 | Result strobe, one cycle after an accepted column |
| match_o | output | 1 | Coincidence found |
| angle_o | output | COORD_W | Index of the lowest coincidence (segment angle) |
| coord_o | output | COORD_W | Column that the result belongs to |

## Verification
The bench builds the unit with WIDTH=64 and DATA_W=16. This gives a six-stage shifter and a four-word window. With these values every shifter stage, every window word, the largest column (63) and the edges where bits are shifted out can all be reached in a short run. Directed cases cover the top bit aligned to angle 0 and bits dropped past the edge. They also cover a write in the same cycle as a hit, and several matches where the encoder must pick the lowest. A long random phase follows, with sparse rows and occasional window rewrites, and a behavioural model checks it on every clock.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  // Width of an index into n items, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dbl_shifter.sv
module dbl_shifter #(
  parameter int WIDTH = 256,
  localparam int SW = dbl_pkg::idx_w(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SW-1:0]    shift_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [0:SW];

  assign stage[0] = data_i;

  // One stage per bit of the shift amount. Stage s moves the row down by 2**s.
  // Bits that leave the bottom are lost, and zeros come in at the top.
  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stage[s+1] = shift_i[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  assign data_o = stage[SW];

  // R3: with a shift of zero the row passes through unchanged.
  always_comb begin
    if (shift_i == '0) assert_zero_shift_identity_R3: assert (data_o == data_i);
  end
endmodule

// File: rtl/dbl_prienc.sv
module dbl_prienc #(
  parameter int N = 256,
  localparam int IW = dbl_pkg::idx_w(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    // Scan from the top down, so the lowest set bit is the last one written.
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;

  // R5: the index points at a set bit, and it is 0 when no bit is set.
  always_comb begin
    assert_index_hits_set_bit_R5: assert (!any_o || vec_i[idx_o]);
    assert_index_zero_when_empty_R5: assert (any_o || idx_o == '0);
  end
endmodule

// File: rtl/dbl_window_reg.sv
module dbl_window_reg #(
  parameter int WIDTH  = 256,
  parameter int DATA_W = 32,
  localparam int NWORDS = WIDTH / DATA_W,
  localparam int ADDR_W = dbl_pkg::idx_w(NWORDS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [WIDTH-1:0]  win_o
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (rst_i)
        win_o[w*DATA_W +: DATA_W] <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(w)))
        win_o[w*DATA_W +: DATA_W] <= wr_data_i;
    end

    // R2: an addressed word takes the written data on the next clock.
    assert_word_written_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && wr_addr_i == ADDR_W'(w)) |=> (win_o[w*DATA_W +: DATA_W] == $past(wr_data_i)));
    // R2: a word that is not addressed keeps its value.
    assert_word_kept_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !(wr_en_i && wr_addr_i == ADDR_W'(w)) |=> $stable(win_o[w*DATA_W +: DATA_W]));
  end

  // R1: the window is empty after reset.
  assert_reset_empty_window_R1: assert property (@(posedge clk_i) rst_i |=> (win_o == '0));
endmodule

// File: rtl/dbl_correlator.sv
module dbl_correlator #(
  parameter int WIDTH  = 256,
  parameter int DATA_W = 32,
  localparam int COORD_W = dbl_pkg::idx_w(WIDTH),
  localparam int NWORDS  = WIDTH / DATA_W,
  localparam int ADDR_W  = dbl_pkg::idx_w(NWORDS)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [WIDTH-1:0]   local_hits_i,
  input  logic               coord_valid_i,
  input  logic [COORD_W-1:0] coord_i,
  output logic               res_valid_o,
  output logic               match_o,
  output logic [COORD_W-1:0] angle_o,
  output logic [COORD_W-1:0] coord_o
);
  logic [WIDTH-1:0]   window;
  logic [WIDTH-1:0]   aligned;
  logic [WIDTH-1:0]   coinc;
  logic               any_hit;
  logic [COORD_W-1:0] first_idx;

  dbl_window_reg #(.WIDTH(WIDTH), .DATA_W(DATA_W)) i_window (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .win_o     (window)
  );

  dbl_shifter #(.WIDTH(WIDTH)) i_shift (
    .data_i  (local_hits_i),
    .shift_i (coord_i),
    .data_o  (aligned)
  );

  // The AND step of the coincidence. The encoder below supplies the OR step.
  assign coinc = aligned & window;

  dbl_prienc #(.N(WIDTH)) i_enc (
    .vec_i (coinc),
    .any_o (any_hit),
    .idx_o (first_idx)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_valid_o <= 1'b0;
      match_o     <= 1'b0;
      angle_o     <= '0;
      coord_o     <= '0;
    end else begin
      res_valid_o <= coord_valid_i;
      match_o     <= coord_valid_i && any_hit;
      angle_o     <= (coord_valid_i && any_hit) ? first_idx : '0;
      if (coord_valid_i) coord_o <= coord_i;
    end
  end

  // R6: an accepted column gives a result strobe on the next cycle.
  assert_result_follows_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    coord_valid_i |=> res_valid_o);
  // R6: the result carries the column it was computed for.
  assert_coord_echo_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    coord_valid_i |=> (coord_o == $past(coord_i)));
  // R7: outputs are quiet and the column is held after an idle cycle.
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !coord_valid_i |=> (!res_valid_o && !match_o && angle_o == '0 && $stable(coord_o)));
  // R8: a write on its own never produces a result.
  assert_write_no_result_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !coord_valid_i) |=> !res_valid_o);
  // R5: a result with no match reports angle 0.
  assert_nomatch_angle_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (res_valid_o && !match_o) |-> (angle_o == '0));
endmodule

// File: tb/test_dbl_correlator.sv
module test_dbl_correlator;
  localparam int W   = 64;
  localparam int DW  = 16;
  localparam int CW  = 6;
  localparam int AW  = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [W-1:0]  hits;
  logic          cvalid;
  logic [CW-1:0] coord;
  logic          res_valid, match;
  logic [CW-1:0] angle, coord_out;

  int total = 0;
  int bad   = 0;

  // Reference model state.
  logic [W-1:0]  en_m;
  logic          exp_rv, exp_match;
  logic [CW-1:0] exp_angle, exp_coord;

  always #10 clk = ~clk;

  dbl_correlator #(.WIDTH(W), .DATA_W(DW)) i_dbl_correlator (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .local_hits_i(hits), .coord_valid_i(cvalid), .coord_i(coord),
    .res_valid_o(res_valid), .match_o(match), .angle_o(angle), .coord_o(coord_out)
  );

  task automatic chk(input string tag, input string what, input int got, input int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, expv);
    end
  endtask

  // Compare the outputs with the values expected from the previous step's inputs.
  task automatic compare(input string tag);
    chk({tag, " R6"}, "res_valid", int'(res_valid), int'(exp_rv));
    chk({tag, " R4"}, "match", int'(match), int'(exp_match));
    chk({tag, " R5"}, "angle", int'(angle), int'(exp_angle));
    chk({tag, " R6"}, "coord", int'(coord_out), int'(exp_coord));
  endtask

  // One cycle: check the outputs, drive new inputs, then update the model.
  task automatic step(input string tag, input logic v, input logic [CW-1:0] c,
                      input logic [W-1:0] h, input logic we,
                      input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    int first;
    @(negedge clk);
    compare(tag);
    cvalid = v; coord = c; hits = h; wr_en = we; wr_addr = wa; wr_data = wd;
    first = -1;
    for (int i = 0; i < W; i++) begin
      if (first < 0 && (i + int'(c)) < W && h[i + int'(c)] && en_m[i]) first = i;
    end
    exp_rv    = v;
    exp_match = v && (first >= 0);
    exp_angle = (v && first >= 0) ? CW'(first) : '0;
    if (v) exp_coord = c;
    if (we) en_m[int'(wa)*DW +: DW] = wd;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, '0, 1'b0, '0, '0);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(tag, 1'b0, '0, '0, 1'b1, a, d);
  endtask

  task automatic hit(input string tag, input logic [CW-1:0] c, input logic [W-1:0] h);
    step(tag, 1'b1, c, h, 1'b0, '0, '0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = '0; wr_data = '0; hits = '0; cvalid = 0; coord = '0;
    en_m = '0; exp_rv = 0; exp_match = 0; exp_angle = '0; exp_coord = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs during reset.
    compare("R1 reset");
    rst = 1'b0;
    idle("R1 after reset");
    // R1: an empty window rejects every hit.
    hit("R1 empty window", 6'd0, {W{1'b1}});
    idle("R1 empty window result");
    // R8: writes alone give no result. R2: word 1 = bit 20.
    wr("R8 write only", 2'd1, 16'h0010);
    idle("R8 write result");
    // R2: hit at bit 25 with column 5 lands on bit 20.
    hit("R2 written word", 6'd5, 64'(1) << 25);
    // R2: a write in the same cycle as a hit, judged on the old window.
    step("R2 same-cycle write", 1'b1, 6'd0, 64'(1) << 40, 1'b1, 2'd2, 16'h0100);
    hit("R2 new window in force", 6'd0, 64'(1) << 40);
    idle("R7 idle after hits");
    idle("R7 idle holds coord");
    // R3: open the whole window.
    for (int k = 0; k < 4; k++) wr("R3 open window", AW'(k), 16'hFFFF);
    hit("R3 top bit to angle 0", 6'd63, 64'(1) << 63);
    hit("R3 shifted out of range", 6'd63, 64'(1) << 62);
    hit("R3 no wrap", 6'd1, 64'(1));
    // R5: several matches, the lowest one wins.
    wr("R5 sparse window", 2'd0, 16'h0000);
    hit("R5 lowest of many", 6'd4, (64'(1) << 30) | (64'(1) << 50) | (64'(1) << 7));
    hit("R5 back-to-back", 6'd0, (64'(1) << 63) | (64'(1) << 17));
    idle("R7 quiet");
    // Random phase.
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] h;
      int r;
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      r = $urandom_range(0, 9);
      if (r == 0)
        wr("R2 random write", AW'($urandom_range(0, 3)), DW'($urandom) & DW'($urandom));
      else if (r == 1)
        idle("R7 random idle");
      else if (r == 2)
        step("R2 random write+hit", 1'b1, CW'($urandom), h, 1'b1,
             AW'($urandom_range(0, 3)), DW'($urandom));
      else
        hit("R4 random hit", CW'($urandom), h);
    end
    idle("R4 drain");
    @(negedge clk);
    compare("R7 final");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule